// File: doc/BRIEF.md
# Thermometer-Code Die Heater Controller

This block keeps the die near a chosen temperature by using part of the fabric as a heat source. The heat source is a bank of flip-flop groups. An enabled group inverts every flip-flop on every clock and so dissipates switching power. A disabled group holds its state and burns only static power. A single enable register chooses how many groups are active. Groups always switch on from the lowest index upward, so the register always holds a thermometer code.

The block reads each die-temperature sample that arrives with its valid strobe. It compares the sample with a target and a hysteresis band, and it moves the thermometer by at most one group per decision. When a decision changes the vector, a settle timer starts. While that timer runs, further samples are ignored, which gives the die time to respond before the next step. The target is normally set close to the top of the expected ambient range, so the heater holds the die at a steady, slightly warm point. A build with one group acts as an on/off thermostat. A build with four groups gives coarse steps of heat.

Top module: `thc_heater_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, every bit of `heat_en` and `heater_q` is 0.
- R2: `heat_en` is always a thermometer code: if bit i is set, every bit below i is also set.
- R3: A decision happens on a clock edge where `temp_valid` is 1 and the settle timer has expired. The decision is "cool" when `temp_sample + hyst_band < temp_target`, and the next `heat_en` then has one more group enabled. The decision is "hot" when `temp_sample > temp_target + hyst_band`, and the next `heat_en` then has one group fewer. All comparisons are unsigned and made without overflow. The change appears on `heat_en` right after that same edge.
- R4: The vector saturates. A cool decision with all groups on leaves `heat_en` unchanged, and so does a hot decision with all groups off. Neither case starts the settle timer.
- R5: A sample in the band `temp_target - hyst_band <= temp_sample <= temp_target + hyst_band` causes no change.
- R6: After an edge that changes `heat_en`, the value of `settle_cycles` at that edge is loaded as the wait N. Samples on the next N edges are ignored, and the earliest edge that can make the next change is the (N+1)th edge. With N = 0, a change can happen on every edge.
- R7: `heat_en` never changes on an edge where `temp_valid` is 0.
- R8: Group g drives bits `[g*FLOPS_PER_GROUP +: FLOPS_PER_GROUP]` of `heater_q`. When `heat_en[g]` was 1 before an edge, each of those bits inverts at that edge. Otherwise the bits hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_sample | input | TEMP_W | Unsigned die temperature reading |
| temp_valid | input | 1 | Qualifies `temp_sample` for one cycle |
| temp_target | input | TEMP_W | Unsigned temperature to hold |
| hyst_band | input | TEMP_W | Half-width of the dead band around the target |
| settle_cycles | input | SETTLE_W | Wait, in cycles, after each change |
| heat_en | output | GROUPS | Thermometer-coded group enables, bit 0 first |
| heater_q | output | GROUPS*FLOPS_PER_GROUP | Outputs of the dissipating flip-flops |

## Verification
On every cycle, the bound checker checks these behaviours:
- the thermometer shape of the enables;
- the single-group step size;
- the direction of each step against the sample that caused it;
- the absence of any change without a valid sample;
- the minimum spacing between changes, counted against the settle value in force at each change;
- the toggle-or-hold rule of every heater group.

Some behaviours only the bench's scenarios can show, because a step that is missing breaks no property:
- a cool or hot sample really moves the vector;
- both saturation ends and both band edges produce no step;
- a timer that has expired lets the step through on exactly the expected edge.

// File: rtl/thc_pkg.sv
package thc_pkg;
  typedef enum logic [1:0] {
    THC_HOLD = 2'd0,
    THC_ADD  = 2'd1,
    THC_DROP = 2'd2
  } thc_step_e;
endpackage

// File: rtl/thc_judge.sv
module thc_judge
  import thc_pkg::*;
#(
  parameter int TEMP_W = 12
) (
  input  logic [TEMP_W-1:0] sample,
  input  logic [TEMP_W-1:0] target,
  input  logic [TEMP_W-1:0] band,
  output thc_step_e         want
);
  logic [TEMP_W:0] sample_plus_band;
  logic [TEMP_W:0] target_plus_band;

  always_comb begin
    sample_plus_band = {1'b0, sample} + {1'b0, band};
    target_plus_band = {1'b0, target} + {1'b0, band};
    if (sample_plus_band < {1'b0, target})
      want = THC_ADD;
    else if ({1'b0, sample} > target_plus_band)
      want = THC_DROP;
    else
      want = THC_HOLD;
  end
endmodule

// File: rtl/thc_settle.sv
module thc_settle #(
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [SETTLE_W-1:0] load_val,
  output logic                ready
);
  logic [SETTLE_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)
      remain <= '0;
    else if (load)
      remain <= load_val;
    else if (remain != '0)
      remain <= remain - 1'b1;
  end

  assign ready = (remain == '0);
endmodule

// File: rtl/thc_therm.sv
module thc_therm
  import thc_pkg::*;
#(
  parameter int GROUPS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              decide,
  input  thc_step_e         want,
  output logic              moved,
  output logic [GROUPS-1:0] en
);
  logic can_add;
  logic can_drop;

  always_comb begin
    can_add  = (want == THC_ADD)  && !en[GROUPS-1];
    can_drop = (want == THC_DROP) && en[0];
    moved    = decide && (can_add || can_drop);
  end

  always_ff @(posedge clk) begin
    if (rst)
      en <= '0;
    else if (decide && can_add)
      en <= (en << 1) | GROUPS'(1);
    else if (decide && can_drop)
      en <= en >> 1;
  end
endmodule

// File: rtl/thc_heat_bank.sv
module thc_heat_bank #(
  parameter int FLOPS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             on,
  output logic [FLOPS-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (on)
      q <= ~q;
  end
endmodule

// File: rtl/thc_heater_ctrl.sv
module thc_heater_ctrl
  import thc_pkg::*;
#(
  parameter int GROUPS          = 4,
  parameter int FLOPS_PER_GROUP = 8,
  parameter int TEMP_W          = 12,
  parameter int SETTLE_W        = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [TEMP_W-1:0]                 temp_sample,
  input  logic                              temp_valid,
  input  logic [TEMP_W-1:0]                 temp_target,
  input  logic [TEMP_W-1:0]                 hyst_band,
  input  logic [SETTLE_W-1:0]               settle_cycles,
  output logic [GROUPS-1:0]                 heat_en,
  output logic [GROUPS*FLOPS_PER_GROUP-1:0] heater_q
);
  thc_step_e want;
  logic      ready;
  logic      decide;
  logic      moved;

  thc_judge #(.TEMP_W(TEMP_W)) u_judge (
    .sample (temp_sample),
    .target (temp_target),
    .band   (hyst_band),
    .want   (want)
  );

  assign decide = temp_valid && ready;

  thc_settle #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk      (clk),
    .rst      (rst),
    .load     (moved),
    .load_val (settle_cycles),
    .ready    (ready)
  );

  thc_therm #(.GROUPS(GROUPS)) u_therm (
    .clk    (clk),
    .rst    (rst),
    .decide (decide),
    .want   (want),
    .moved  (moved),
    .en     (heat_en)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_bank
    thc_heat_bank #(.FLOPS(FLOPS_PER_GROUP)) u_bank (
      .clk (clk),
      .rst (rst),
      .on  (heat_en[g]),
      .q   (heater_q[g*FLOPS_PER_GROUP +: FLOPS_PER_GROUP])
    );
  end
endmodule

// File: rtl/thc_heater_ctrl_chk.sv
module thc_heater_ctrl_chk #(
  parameter int GROUPS          = 4,
  parameter int FLOPS_PER_GROUP = 8,
  parameter int TEMP_W          = 12,
  parameter int SETTLE_W        = 16
) (
  input logic                              clk,
  input logic                              rst,
  input logic [TEMP_W-1:0]                 temp_sample,
  input logic                              temp_valid,
  input logic [TEMP_W-1:0]                 temp_target,
  input logic [TEMP_W-1:0]                 hyst_band,
  input logic [SETTLE_W-1:0]               settle_cycles,
  input logic [GROUPS-1:0]                 heat_en,
  input logic [GROUPS*FLOPS_PER_GROUP-1:0] heater_q
);
  logic [GROUPS-1:0]   en_q;
  logic [SETTLE_W-1:0] set_q;
  logic [SETTLE_W-1:0] lim;
  logic [SETTLE_W:0]   since;
  logic                seen;
  logic                therm_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      set_q <= '0;
      lim   <= '0;
      since <= '0;
      seen  <= 1'b0;
    end else begin
      en_q  <= heat_en;
      set_q <= settle_cycles;
      if (heat_en != en_q) begin
        seen  <= 1'b1;
        since <= (SETTLE_W+1)'(1);
        lim   <= set_q;
      end else if (since != '1) begin
        since <= since + 1'b1;
      end
    end
  end

  assign therm_ok = ((heat_en + GROUPS'(1)) & heat_en) == '0;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (heat_en == '0 && heater_q == '0));

  a_r2_thermometer: assert property (@(posedge clk) disable iff (rst)
    therm_ok);

  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(heat_en) <= $countones($past(heat_en)) + 1 &&
              $countones($past(heat_en)) <= $countones(heat_en) + 1));

  a_r3_add_when_cool: assert property (@(posedge clk) disable iff (rst)
    ($countones(heat_en) > $countones(en_q)) |->
      ({1'b0, $past(temp_sample)} + {1'b0, $past(hyst_band)} < {1'b0, $past(temp_target)}));

  a_r3_drop_when_hot: assert property (@(posedge clk) disable iff (rst)
    ($countones(heat_en) < $countones(en_q)) |->
      ({1'b0, $past(temp_sample)} > {1'b0, $past(temp_target)} + {1'b0, $past(hyst_band)}));

  a_r6_settle_gap: assert property (@(posedge clk) disable iff (rst)
    (seen && heat_en != en_q) |-> (since > {1'b0, lim}));

  a_r7_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (heat_en != en_q) |-> $past(temp_valid));

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    a_r8_hold_off: assert property (@(posedge clk) disable iff (rst)
      !en_q[g] |-> $stable(heater_q[g*FLOPS_PER_GROUP +: FLOPS_PER_GROUP]));
    a_r8_toggle_on: assert property (@(posedge clk) disable iff (rst)
      en_q[g] |-> (heater_q[g*FLOPS_PER_GROUP +: FLOPS_PER_GROUP] ==
                   ~$past(heater_q[g*FLOPS_PER_GROUP +: FLOPS_PER_GROUP])));
  end
endmodule

bind thc_heater_ctrl thc_heater_ctrl_chk #(
  .GROUPS(GROUPS), .FLOPS_PER_GROUP(FLOPS_PER_GROUP),
  .TEMP_W(TEMP_W), .SETTLE_W(SETTLE_W)
) u_chk (
  .clk(clk), .rst(rst), .temp_sample(temp_sample), .temp_valid(temp_valid),
  .temp_target(temp_target), .hyst_band(hyst_band), .settle_cycles(settle_cycles),
  .heat_en(heat_en), .heater_q(heater_q)
);

// File: tb/thc_heater_ctrl_tb.sv
module thc_heater_ctrl_tb;
  localparam int G  = 4;
  localparam int F  = 8;
  localparam int TW = 12;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] temp_sample = '0;
  logic          temp_valid = 1'b0;
  logic [TW-1:0] temp_target = TW'(1000);
  logic [TW-1:0] hyst_band = TW'(4);
  logic [SW-1:0] settle_cycles = '0;
  logic [G-1:0]  heat_en;
  logic [G*F-1:0] heater_q;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  thc_heater_ctrl #(.GROUPS(G), .FLOPS_PER_GROUP(F), .TEMP_W(TW), .SETTLE_W(SW)) u_dut (
    .clk(clk), .rst(rst), .temp_sample(temp_sample), .temp_valid(temp_valid),
    .temp_target(temp_target), .hyst_band(hyst_band), .settle_cycles(settle_cycles),
    .heat_en(heat_en), .heater_q(heater_q)
  );

  // behavioural reference: group count, wait counter, per-group toggle bit
  int ref_n    = 0;
  int ref_wait = 0;
  bit ref_h[G];
  bit live     = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      ref_n = 0; ref_wait = 0; live = 1'b1;
      foreach (ref_h[i]) ref_h[i] = 1'b0;
    end else begin
      foreach (ref_h[i]) if (i < ref_n) ref_h[i] = !ref_h[i];
      if (ref_wait > 0) ref_wait--;
      else if (temp_valid) begin
        if (int'(temp_sample) + int'(hyst_band) < int'(temp_target)) begin
          if (ref_n < G) begin ref_n++; ref_wait = int'(settle_cycles); end
        end else if (int'(temp_sample) > int'(temp_target) + int'(hyst_band)) begin
          if (ref_n > 0) begin ref_n--; ref_wait = int'(settle_cycles); end
        end
      end
    end
  end

  function automatic logic [G-1:0] therm(int n);
    return G'((1 << n) - 1);
  endfunction

  function automatic logic [G*F-1:0] heat_vec();
    logic [G*F-1:0] v;
    for (int i = 0; i < G*F; i++) v[i] = ref_h[i / F];
    return v;
  endfunction

  always @(negedge clk) begin
    if (live) begin
      checks++;
      if (heat_en !== therm(ref_n)) begin
        fails++;
        $display("FAIL R2/R3/R4/R5/R6/R7 enable: got %b expected %b", heat_en, therm(ref_n));
      end
      checks++;
      if (heater_q !== heat_vec()) begin
        fails++;
        $display("FAIL R8 heater: got %h expected %h", heater_q, heat_vec());
      end
    end
  end

  task automatic expect_n(int n, string tag);
    checks++;
    if (heat_en !== therm(n)) begin
      fails++;
      $display("FAIL %s: heat_en got %b expected %b", tag, heat_en, therm(n));
    end
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(int t, bit v);
    temp_sample = TW'(t);
    temp_valid  = v;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end

  initial begin
    wait_cycles(3);
    expect_n(0, "R1");
    checks++;
    if (heater_q !== '0) begin
      fails++;
      $display("FAIL R1 heater: got %h expected 0", heater_q);
    end
    rst = 1'b0;
    wait_cycles(1);
    expect_n(0, "R1");

    // R3: two cool samples add two groups
    drive(900, 1'b1); wait_cycles(2);
    expect_n(2, "R3");
    // R7: cool but not valid
    drive(900, 1'b0); wait_cycles(3);
    expect_n(2, "R7");
    // R5: both band edges hold
    drive(1004, 1'b1); wait_cycles(3);
    expect_n(2, "R5");
    drive(996, 1'b1); wait_cycles(3);
    expect_n(2, "R5");
    // R3: just above the band drops one
    drive(1005, 1'b1); wait_cycles(1);
    expect_n(1, "R3");
    // R4: saturate high
    drive(900, 1'b1); wait_cycles(10);
    expect_n(4, "R4");
    // R6: settle of five
    settle_cycles = SW'(5);
    drive(1100, 1'b1); wait_cycles(1);
    expect_n(3, "R6");
    wait_cycles(5);
    expect_n(3, "R6");
    wait_cycles(1);
    expect_n(2, "R6");
    // R4: saturate low
    settle_cycles = '0;
    wait_cycles(12);
    expect_n(0, "R4");
    drive(1100, 1'b0); wait_cycles(3);
    expect_n(0, "R8");
    finish_run();
  end
endmodule